// File: doc/BRIEF.md
# Multiplexed BCD Digit Scanner with Capture Strobe

This block takes five already-latched decimal digits and presents them one at a time on a shared four-bit BCD bus, with a one-hot set of digit-drive outputs telling a display or a capture circuit which digit is on the bus. The scan runs most significant digit first, down to the least significant, and wraps around continuously.

When a measurement finishes, the block waits a fixed delay, then restarts the scan at the most significant digit and issues a burst of five short active-low strobe pulses, one in the middle of each digit slot. External latches, a serial transmitter or a processor use those pulses to capture each digit exactly once per reading. The first slot of a burst is one count longer than the others. After the burst the scan keeps running without strobes. If the reading was out of range when the burst ends, every digit drive is blanked until the converter's reference-integrate phase begins, which makes the display blink.

Controller states: `ST_IDLE` (after reset, blank, waiting for the first reading), `ST_BURST` (scanning with strobes), `ST_SCAN` (scanning, no strobes), `ST_BLANK` (overrange blanking). Transitions: IDLE to BURST on start-timer expiry; BURST to BURST on a new expiry; BURST to SCAN at the end of the least significant slot when the overrange flag is low; BURST to BLANK at that point when it is high; SCAN to BURST and BLANK to BURST on start-timer expiry; BLANK to SCAN on the reference-integrate event.

Top module: `digit_scanner`

## Requirements
- R1: While reset is asserted and after its release until the first measurement-done event takes effect, every digit drive and the BCD bus are 0 and the strobe stays high.
- R2: Digit drives are one-hot or all zero; bit 4 of `drive_o` is the most significant digit and bit 0 the least; the scan visits bit 4, 3, 2, 1, 0 and then bit 4 again; while drive bit i is high the bus carries `digits_i[4*i+3:4*i]`.
- R3: Bit 4 of `drive_o` rises START_DELAY clocks after the clock edge that samples `meas_done_i` high; if a digit was being shown, its slot is cut short at that edge.
- R4: The first slot of a strobe burst lasts SLOT_LEN+FIRST_EXTRA clocks; every other slot lasts SLOT_LEN clocks.
- R5: In each slot of a burst, `strobe_n_o` is low exactly during the low half of the clock cycle that begins STROBE_AT clocks after the slot start, and is high during every high clock half.
- R6: Exactly five strobe pulses occur per measurement; scans that follow a burst, the blank interval and the idle state produce none.
- R7: The BCD bus changes only together with a digit-drive edge; a change of `digits_i` inside a slot appears at the next slot.
- R8: If `ovr_i` is high at the end of the last slot of a burst, drives and bus go to 0 until `ref_start_i` is sampled high; at that edge the scan restarts at bit 4 with a normal-length slot and without strobes.
- R9: `ref_start_i` has no effect outside the blank interval; a measurement-done event during the blank interval starts a new burst START_DELAY clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock; its low phase also shapes the strobe |
| rst_n | input | 1 | Asynchronous active-low reset |
| digits_i | input | NUM_DIGITS*DIGIT_W | Latched digits, nibble i is digit i, nibble 4 most significant |
| meas_done_i | input | 1 | One-cycle pulse at the end of a measurement |
| ovr_i | input | 1 | Overrange flag of the current reading |
| ref_start_i | input | 1 | One-cycle pulse when reference integration begins |
| drive_o | output | NUM_DIGITS | One-hot digit drives, bit 4 most significant |
| bcd_o | output | DIGIT_W | Shared BCD bus, active high |
| strobe_n_o | output | 1 | Active-low half-clock capture pulse |

## Verification
The bench builds the scanner with SLOT_LEN=12, FIRST_EXTRA=1, STROBE_AT=6 and START_DELAY=7, so a whole burst fits in 61 clocks and a full scan round in 60. That brings several bursts, scans between them, two truncated slots, two overrange blank intervals, a reading that arrives during blanking and ignored reference-integrate events into a run of under a thousand cycles, each checked as a sequence of digit segments with their length, bus value and strobe count and position.

// File: rtl/scan_pkg.sv
package scan_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_SCAN  = 2'd2,
        ST_BLANK = 2'd3
    } scan_state_e;
endpackage

// File: rtl/scan_start_timer.sv
// Counts the fixed delay between end of measurement and the start of the burst.
module scan_start_timer #(
    parameter int START_DELAY = 101
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic fire_o
);
    localparam int CW = $clog2(START_DELAY + 1);
    localparam logic [CW-1:0] LOAD = CW'(START_DELAY - 1);

    logic [CW-1:0] cnt_q;
    logic          pend_q;

    assign fire_o = pend_q && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else if (start_i) begin
            cnt_q  <= LOAD;
            pend_q <= 1'b1;
        end else if (fire_o) begin
            pend_q <= 1'b0;
        end else if (pend_q) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/scan_slot_timer.sv
// Position counter inside the current digit slot.
module scan_slot_timer #(
    parameter int SLOT_LEN    = 200,
    parameter int FIRST_EXTRA = 1,
    parameter int STROBE_AT   = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic long_i,
    input  logic run_i,
    output logic end_o,
    output logic mid_o
);
    localparam int LONG_LEN = SLOT_LEN + FIRST_EXTRA;
    localparam int CW = $clog2(LONG_LEN + 1);
    localparam logic [CW-1:0] LAST_LONG  = CW'(LONG_LEN - 1);
    localparam logic [CW-1:0] LAST_SHORT = CW'(SLOT_LEN - 1);
    localparam logic [CW-1:0] MID_POS    = CW'(STROBE_AT);

    logic [CW-1:0] cnt_q;
    logic          long_q;

    assign end_o = run_i && (cnt_q == (long_q ? LAST_LONG : LAST_SHORT));
    assign mid_o = (cnt_q == MID_POS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            long_q <= 1'b0;
        end else if (restart_i) begin
            cnt_q  <= '0;
            long_q <= long_i;
        end else if (run_i) begin
            if (end_o) begin
                cnt_q  <= '0;
                long_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/scan_digit_mux.sv
// Index to one-hot drive and nibble selection.
module scan_digit_mux #(
    parameter int NUM_DIGITS = 5,
    parameter int DIGIT_W    = 4,
    parameter int IW         = 3
) (
    input  logic [IW-1:0]                 idx_i,
    input  logic [NUM_DIGITS*DIGIT_W-1:0] digits_i,
    output logic [NUM_DIGITS-1:0]         drive_o,
    output logic [DIGIT_W-1:0]            nib_o
);
    logic [DIGIT_W-1:0] nib_arr [NUM_DIGITS];

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_dig
        assign drive_o[g] = (idx_i == IW'(g));
        assign nib_arr[g] = digits_i[g*DIGIT_W +: DIGIT_W];
    end

    always_comb begin
        nib_o = '0;
        for (int i = 0; i < NUM_DIGITS; i++) begin
            if (idx_i == IW'(i)) nib_o = nib_arr[i];
        end
    end
endmodule

// File: rtl/scan_fsm.sv
// Scan controller: state register, next-state logic, registered outputs.
module scan_fsm
    import scan_pkg::*;
#(
    parameter int NUM_DIGITS = 5,
    parameter int DIGIT_W    = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          fire_i,
    input  logic                          ref_start_i,
    input  logic                          ovr_i,
    input  logic                          slot_end_i,
    input  logic [NUM_DIGITS*DIGIT_W-1:0] digits_i,
    output scan_state_e                   state_o,
    output logic                          restart_o,
    output logic                          long_o,
    output logic [NUM_DIGITS-1:0]         drive_o,
    output logic [DIGIT_W-1:0]            bcd_o
);
    localparam int IW = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;
    localparam logic [IW-1:0] TOP_IDX = IW'(NUM_DIGITS - 1);

    scan_state_e state_q, nxt_state;
    logic [IW-1:0] idx_q, nxt_idx;
    logic          load;
    logic [NUM_DIGITS-1:0] drv_nxt;
    logic [DIGIT_W-1:0]    nib_nxt;

    assign state_o = state_q;

    // next state and slot bookkeeping
    always_comb begin
        nxt_state = state_q;
        nxt_idx   = idx_q;
        restart_o = 1'b0;
        long_o    = 1'b0;
        load      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (fire_i) begin
                    nxt_state = ST_BURST;
                    nxt_idx   = TOP_IDX;
                    restart_o = 1'b1;
                    long_o    = 1'b1;
                    load      = 1'b1;
                end
            end
            ST_BURST: begin
                if (fire_i) begin
                    nxt_idx   = TOP_IDX;
                    restart_o = 1'b1;
                    long_o    = 1'b1;
                    load      = 1'b1;
                end else if (slot_end_i) begin
                    load = 1'b1;
                    if (idx_q == '0) begin
                        nxt_idx   = TOP_IDX;
                        nxt_state = ovr_i ? ST_BLANK : ST_SCAN;
                    end else begin
                        nxt_idx = idx_q - 1'b1;
                    end
                end
            end
            ST_SCAN: begin
                if (fire_i) begin
                    nxt_state = ST_BURST;
                    nxt_idx   = TOP_IDX;
                    restart_o = 1'b1;
                    long_o    = 1'b1;
                    load      = 1'b1;
                end else if (slot_end_i) begin
                    load    = 1'b1;
                    nxt_idx = (idx_q == '0) ? TOP_IDX : idx_q - 1'b1;
                end
            end
            ST_BLANK: begin
                if (fire_i) begin
                    nxt_state = ST_BURST;
                    nxt_idx   = TOP_IDX;
                    restart_o = 1'b1;
                    long_o    = 1'b1;
                    load      = 1'b1;
                end else if (ref_start_i) begin
                    nxt_state = ST_SCAN;
                    nxt_idx   = TOP_IDX;
                    restart_o = 1'b1;
                    load      = 1'b1;
                end
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= TOP_IDX;
        end else begin
            state_q <= nxt_state;
            idx_q   <= nxt_idx;
        end
    end

    scan_digit_mux #(
        .NUM_DIGITS (NUM_DIGITS),
        .DIGIT_W    (DIGIT_W),
        .IW         (IW)
    ) u_mux (
        .idx_i    (nxt_idx),
        .digits_i (digits_i),
        .drive_o  (drv_nxt),
        .nib_o    (nib_nxt)
    );

    // registered outputs: bus and drives move together, only at slot starts
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive_o <= '0;
            bcd_o   <= '0;
        end else if (nxt_state == ST_IDLE || nxt_state == ST_BLANK) begin
            drive_o <= '0;
            bcd_o   <= '0;
        end else if (load) begin
            drive_o <= drv_nxt;
            bcd_o   <= nib_nxt;
        end
    end
endmodule

// File: rtl/digit_scanner.sv
module digit_scanner
    import scan_pkg::*;
#(
    parameter int NUM_DIGITS  = 5,
    parameter int DIGIT_W     = 4,
    parameter int SLOT_LEN    = 200,
    parameter int FIRST_EXTRA = 1,
    parameter int STROBE_AT   = 100,
    parameter int START_DELAY = 101
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_DIGITS*DIGIT_W-1:0] digits_i,
    input  logic                          meas_done_i,
    input  logic                          ovr_i,
    input  logic                          ref_start_i,
    output logic [NUM_DIGITS-1:0]         drive_o,
    output logic [DIGIT_W-1:0]            bcd_o,
    output logic                          strobe_n_o
);
    scan_state_e state;
    logic fire, restart, long_slot, slot_end, slot_mid, running, in_burst;

    assign running  = (state == ST_BURST) || (state == ST_SCAN);
    assign in_burst = (state == ST_BURST);

    scan_start_timer #(
        .START_DELAY (START_DELAY)
    ) u_start (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (meas_done_i),
        .fire_o  (fire)
    );

    scan_slot_timer #(
        .SLOT_LEN    (SLOT_LEN),
        .FIRST_EXTRA (FIRST_EXTRA),
        .STROBE_AT   (STROBE_AT)
    ) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .long_i    (long_slot),
        .run_i     (running),
        .end_o     (slot_end),
        .mid_o     (slot_mid)
    );

    scan_fsm #(
        .NUM_DIGITS (NUM_DIGITS),
        .DIGIT_W    (DIGIT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire_i      (fire),
        .ref_start_i (ref_start_i),
        .ovr_i       (ovr_i),
        .slot_end_i  (slot_end),
        .digits_i    (digits_i),
        .state_o     (state),
        .restart_o   (restart),
        .long_o      (long_slot),
        .drive_o     (drive_o),
        .bcd_o       (bcd_o)
    );

    // Registered enables, low clock half: pulse is half a clock wide and
    // sits away from the edge where bus and drives change.
    assign strobe_n_o = ~(in_burst & slot_mid & ~clk);
endmodule

// File: rtl/scan_checker.sv
module scan_checker #(
    parameter int NUM_DIGITS = 5,
    parameter int DIGIT_W    = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_DIGITS*DIGIT_W-1:0] digits_i,
    input logic [NUM_DIGITS-1:0]         drive_o,
    input logic [DIGIT_W-1:0]            bcd_o
);
    function automatic logic [DIGIT_W-1:0] pick(
        input logic [NUM_DIGITS*DIGIT_W-1:0] d,
        input logic [NUM_DIGITS-1:0]         sel
    );
        logic [DIGIT_W-1:0] r;
        r = '0;
        for (int i = 0; i < NUM_DIGITS; i++) begin
            if (sel[i]) r = d[i*DIGIT_W +: DIGIT_W];
        end
        return r;
    endfunction

    AST_RESET_BLANK: assert property (@(posedge clk)
        !rst_n |-> (drive_o == '0 && bcd_o == '0)); // R1

    AST_DRIVE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drive_o)); // R2

    AST_SCAN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_o != '0 && $past(drive_o) != '0 && drive_o != $past(drive_o))
        |-> (drive_o == ($past(drive_o) >> 1) || drive_o[NUM_DIGITS-1])); // R2

    AST_BLANK_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_o == '0) |-> (bcd_o == '0)); // R8

    AST_SLOT_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_o != '0 && drive_o != $past(drive_o))
        |-> (bcd_o == pick($past(digits_i), drive_o))); // R7
endmodule

bind digit_scanner scan_checker #(
    .NUM_DIGITS (NUM_DIGITS),
    .DIGIT_W    (DIGIT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .digits_i (digits_i),
    .drive_o  (drive_o),
    .bcd_o    (bcd_o)
);

// File: tb/sim_digit_scanner.sv
`timescale 1ns/1ps
module sim_digit_scanner;
    localparam int S = 12;
    localparam int F = 1;
    localparam int C = 6;
    localparam int P = 7;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [19:0] digits;
    logic        done_p, ovr, ref_p;
    logic [4:0]  drive_o;
    logic [3:0]  bcd_o;
    logic        strobe_n_o;

    always #4 clk = ~clk;

    digit_scanner #(
        .NUM_DIGITS (5), .DIGIT_W (4), .SLOT_LEN (S),
        .FIRST_EXTRA (F), .STROBE_AT (C), .START_DELAY (P)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .digits_i (digits),
        .meas_done_i (done_p), .ovr_i (ovr), .ref_start_i (ref_p),
        .drive_o (drive_o), .bcd_o (bcd_o), .strobe_n_o (strobe_n_o)
    );

    typedef struct {
        logic [4:0] drv;
        logic [3:0] bcd;
        int         len;
        int         nstb;
        string      tag;
    } seg_t;

    seg_t exp_q[$];
    int errors = 0, checks = 0, hi_low = 0, tnow = 0;
    bit mon_on = 0, seg_open = 0, finished = 0;
    logic [4:0] cur_drv;
    logic [3:0] cur_bcd;
    int seg_len, seg_nstb, seg_pos;

    localparam logic [19:0] DA = {4'd1, 4'd9, 4'd3, 4'd7, 4'd0};
    localparam logic [19:0] DB = {4'd2, 4'd8, 4'd5, 4'd4, 4'd6};
    localparam logic [19:0] DC = {4'd1, 4'd0, 4'd0, 4'd2, 4'd9};

    task automatic check(input bit ok, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
        end
    endtask

    task automatic push(input logic [4:0] d, input logic [3:0] b, input int l, input int n, input string t);
        seg_t e;
        e.drv = d; e.bcd = b; e.len = l; e.nstb = n; e.tag = t;
        exp_q.push_back(e);
    endtask

    task automatic push_one(input logic [19:0] dg, input int i, input int l, input int n, input string t);
        push(5'b1 << i, dg[i*4 +: 4], l, n, t);
    endtask

    // five slots from the most significant digit down
    task automatic push_round(input logic [19:0] dg, input bit burst, input string t);
        for (int i = 4; i >= 0; i--) begin
            push_one(dg, i, (burst && i == 4) ? S + F : S, burst ? 1 : 0, t);
        end
    endtask

    task automatic close_seg();
        seg_t e;
        bit ok;
        checks++;
        if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R2 unexpected segment drive=%b bcd=%0d len=%0d actual=%0d expected=%0d",
                     cur_drv, cur_bcd, seg_len, seg_len, 0);
        end else begin
            e = exp_q.pop_front();
            ok = (cur_drv == e.drv) && (cur_bcd == e.bcd) &&
                 (e.len == 0 || seg_len == e.len) && (seg_nstb == e.nstb) &&
                 (e.nstb != 1 || seg_pos == C);
            if (!ok) begin
                errors++;
                $display("FAIL %s segment actual drive=%b bcd=%0d len=%0d strobes=%0d pos=%0d expected drive=%b bcd=%0d len=%0d strobes=%0d pos=%0d",
                         e.tag, cur_drv, cur_bcd, seg_len, seg_nstb, seg_pos,
                         e.drv, e.bcd, e.len, e.nstb, C);
            end
        end
    endtask

    task automatic open_seg();
        cur_drv  = drive_o;
        cur_bcd  = bcd_o;
        seg_len  = 1;
        seg_nstb = (strobe_n_o == 1'b0) ? 1 : 0;
        seg_pos  = 0;
        seg_open = 1;
    endtask

    // monitor: high-phase strobe check at +2, segment sampling at +6
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (mon_on && strobe_n_o !== 1'b1) hi_low++;
            #4;
            if (mon_on) begin
                if (!seg_open) open_seg();
                else if (drive_o !== cur_drv || bcd_o !== cur_bcd) begin
                    close_seg();
                    open_seg();
                end else begin
                    seg_len++;
                    if (strobe_n_o == 1'b0) begin
                        if (seg_nstb == 0) seg_pos = seg_len - 1;
                        seg_nstb++;
                    end
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
        tnow += n;
    endtask

    task automatic goto(input int t);
        if (t > tnow) step(t - tnow);
    endtask

    task automatic pulse_done(output int t);
        done_p = 1'b1;
        step(1);
        done_p = 1'b0;
        t = tnow;
    endtask

    task automatic pulse_ref(output int t);
        ref_p = 1'b1;
        step(1);
        ref_p = 1'b0;
        t = tnow;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int t0, t1, t2, t3, r, rx;
        rst_n = 1'b0; digits = '0; done_p = 0; ovr = 0; ref_p = 0;
        repeat (3) @(posedge clk);
        #6;
        check(drive_o == 5'd0, "R1 reset drive", drive_o, 0);
        check(bcd_o == 4'd0, "R1 reset bcd", bcd_o, 0);
        check(strobe_n_o == 1'b1, "R1 reset strobe", strobe_n_o, 1);
        @(posedge clk); #2;
        rst_n = 1'b1;
        tnow = 0;
        mon_on = 1;

        // idle blank before the first reading, no strobes (R1, R6)
        push(5'd0, 4'd0, 0, 0, "R1");
        goto(3);
        pulse_ref(rx);          // ignored while idle (R9)
        goto(10);
        digits = DA;
        push_round(DA, 1, "R4/R5");
        push_round(DA, 0, "R6");
        push_round(DA, 0, "R2");
        push_one(DA, 4, S, 0, "R2");
        push_one(DB, 3, S, 0, "R7");    // new digits seen from the next slot
        push_one(DB, 2, 10, 0, "R3");   // slot cut by the next burst
        pulse_done(t0);
        goto(t0 + 191);
        digits = DB;
        goto(t0 + 214);
        pulse_done(t1);
        ovr = 1'b1;
        push_round(DB, 1, "R3/R5");
        push(5'd0, 4'd0, 25, 0, "R8");
        push_round(DB, 0, "R8");
        push_round(DB, 0, "R9");
        push_one(DB, 4, S, 0, "R2");
        push_one(DB, 3, 9, 0, "R3");
        push_round(DB, 1, "R6");
        push(5'd0, 4'd0, 17, 0, "R9");
        push_round(DC, 1, "R4/R5");
        push_round(DC, 0, "R8");
        goto(t1 + 92);
        pulse_ref(r);
        goto(r + 14);
        pulse_ref(rx);          // ignored while scanning (R9)
        goto(r + 133);
        pulse_done(t2);
        goto(r + 205);
        ovr = 1'b0;
        digits = DC;            // no effect while blank (R8)
        goto(r + 211);
        pulse_done(t3);
        goto(r + 345);
        mon_on = 0;

        check(exp_q.size() == 0, "R6 expected segments left", exp_q.size(), 0);
        check(hi_low == 0, "R5 strobe low in high clock phase", hi_low, 0);
        check(t3 - t2 == 78 && r - t1 == 93, "R3 bench timeline", t3 - t2, 78);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule